// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbiter

This block collects up to eight interrupt lines and decides which one the processor should serve next. Each line is latched into a pending-request register. It is latched on a rising edge or by following its level, depending on a per-line trigger-mode setting. A mask register can hide any line from arbitration. An in-service register records which lines the processor is currently handling.

Priority is counted from a movable rotation base. The line at the base has rank 0, the next line up has rank 1, and the count wraps modulo the number of lines. The best unmasked request raises the pending output only if its rank is strictly better than the best in-service rank. Software drives the block through a one-cycle command strobe. The strobe carries an opcode, a line number and a data byte. The commands cover acknowledge, the end-of-interrupt variants, setting the base, mask and trigger-mode writes, and the automatic end-of-interrupt options. The pending flag and the winning line number are derived combinationally from the registered state.

Top module: `rot_prio_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the requests, remembered input levels, mask, in-service bits, trigger modes, automatic end-of-interrupt options and the rotation base. After reset `int_pending` is 0.
- R2: With base B, the rank of line L is (L - B) mod 8. Among unmasked requests, the line with the smallest rank wins and appears on `int_line` whenever `int_pending` is 1.
- R3: `int_pending` is 1 exactly when the best unmasked request rank is strictly smaller than the best in-service rank. An empty set has rank 8, so there is no pending output without a request, and any request raises it while nothing is in service.
- R4: On an edge line (trigger bit 0), the request bit sets when the input is high and the level remembered from the previous cycle is low. A falling input or a held-high input does not change the request bit.
- R5: On a level line (trigger bit 1), the request bit follows the input every cycle. Opcode 8 loads the trigger-mode register from `cmd_data`.
- R6: Opcode 7 loads the mask from `cmd_data`, where bit L = 1 hides line L. A masked line never wins. Its request bit is kept and wins again once the line is unmasked.
- R7: Acknowledge (opcode 1) while `int_pending` is 1 sets the winner's in-service bit and clears its request bit only for an edge line. An acknowledge while `int_pending` is 0 changes nothing. If an acknowledge clears a request bit in the same cycle as a new edge on that line, the clear wins.
- R8: Opcode 9 takes automatic end-of-interrupt from `cmd_data[0]` and rotate-on-automatic from `cmd_data[1]`. With the first set, an acknowledge leaves the in-service bits unchanged. With both set, the acknowledge also moves the base to (winner + 1) mod 8.
- R9: Non-specific end-of-interrupt (opcode 2) clears the best-ranked in-service bit. Its rotating form (opcode 3) also moves the base to (that line + 1) mod 8. Both do nothing when no line is in service.
- R10: Specific end-of-interrupt (opcode 4) clears the in-service bit of `cmd_line`. Opcode 5 does the same and sets the base to (`cmd_line` + 1) mod 8. Set-priority (opcode 6) only sets the base to (`cmd_line` + 1) mod 8. Opcode 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | 8 | Interrupt input lines |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_line | input | 3 | Line number for specific and priority commands |
| cmd_data | input | 8 | Data for mask, trigger-mode and mode writes |
| int_pending | output | 1 | An unmasked request outranks everything in service |
| int_line | output | 3 | Winning line number, valid while int_pending is 1 |

## Verification
Every result is due one clock edge after its stimulus. A line change or a command presented before edge N updates the registers at edge N. The combinational outputs then show the effect right after that edge, with no further delay. The bench drives inputs one time unit after an edge and samples the outputs one time unit after the next edge. A reference model in the bench is advanced once per edge, using its pre-edge state, so each check compares against the value due in that cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_ACK      = 4'd1,
    OP_EOI      = 4'd2,
    OP_EOI_ROT  = 4'd3,
    OP_SEOI     = 4'd4,
    OP_SEOI_ROT = 4'd5,
    OP_SETPRIO  = 4'd6,
    OP_MASK     = 4'd7,
    OP_TRIG     = 4'd8,
    OP_MODE     = 4'd9
  } arb_op_e;

endpackage

// File: rtl/arb_line_capture.sv
module arb_line_capture (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic level_i,
  input  logic ack_clr_i,
  output logic irr_o
);

  logic last_q;
  logic rising;

  assign rising = irq_i && !last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_o  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      last_q <= irq_i;
      if (level_i)
        irr_o <= irq_i;
      else if (ack_clr_i)
        irr_o <= 1'b0;
      else if (rising)
        irr_o <= 1'b1;
    end
  end

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    level_i |=> (irr_o == $past(irq_i)));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!level_i && irr_o && !ack_clr_i) |=> irr_o);

  // R4
  edge_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!level_i && irq_i && !last_q && !ack_clr_i) |=> irr_o);

endmodule

// File: rtl/arb_prio_find.sv
module arb_prio_find #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] base_i,
  output logic [LW:0]   rank_o
);

  function automatic logic [LW-1:0] wrap_idx(input int k, input logic [LW-1:0] b);
    return LW'(k) + b;
  endfunction

  logic [N-1:0] rot;

  for (genvar k = 0; k < N; k++) begin : g_rot
    assign rot[k] = vec_i[wrap_idx(k, base_i)];
  end

  always_comb begin
    rank_o = (LW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = (LW+1)'(k);
    end
  end

endmodule

// File: rtl/rot_prio_arbiter.sv
module rot_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_i,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [LW-1:0]     cmd_line,
  input  logic [NLINES-1:0] cmd_data,
  output logic              int_pending,
  output logic [LW-1:0]     int_line
);

  localparam logic [LW:0] RANK_NONE = (LW+1)'(NLINES);

  function automatic logic [LW-1:0] rank_to_line(input logic [LW:0] r, input logic [LW-1:0] b);
    return r[LW-1:0] + b;
  endfunction

  function automatic logic [LW-1:0] after_line(input logic [LW-1:0] l);
    return l + LW'(1);
  endfunction

  function automatic logic [NLINES-1:0] line_bit(input logic [LW-1:0] l);
    return NLINES'(1) << l;
  endfunction

  logic [NLINES-1:0] irr_q, imr_q, isr_q, trig_q;
  logic [LW-1:0]     base_q;
  logic              aeoi_q, raeoi_q;

  logic [NLINES-1:0] req_vec;
  logic [LW:0]       req_rank, svc_rank;
  logic [LW-1:0]     win_line, svc_line;
  logic              svc_any;

  logic is_ack, is_eoi, is_eoi_rot, is_seoi, is_seoi_rot, is_setprio;
  logic is_mask, is_trig, is_mode;
  logic ack_fire;
  logic [NLINES-1:0] ack_clr, isr_set, isr_clr;
  logic              base_load;
  logic [LW-1:0]     base_next;
  logic              unused_mode_bits;

  assign unused_mode_bits = ^cmd_data[NLINES-1:2];

  assign req_vec = irr_q & ~imr_q;

  arb_prio_find #(.N(NLINES)) u_req_rank (
    .vec_i  (req_vec),
    .base_i (base_q),
    .rank_o (req_rank)
  );

  arb_prio_find #(.N(NLINES)) u_svc_rank (
    .vec_i  (isr_q),
    .base_i (base_q),
    .rank_o (svc_rank)
  );

  assign win_line    = rank_to_line(req_rank, base_q);
  assign svc_line    = rank_to_line(svc_rank, base_q);
  assign svc_any     = (svc_rank != RANK_NONE);
  assign int_pending = (req_rank < svc_rank);
  assign int_line    = win_line;

  assign is_ack      = cmd_valid && (cmd_op == OP_ACK);
  assign is_eoi      = cmd_valid && (cmd_op == OP_EOI);
  assign is_eoi_rot  = cmd_valid && (cmd_op == OP_EOI_ROT);
  assign is_seoi     = cmd_valid && (cmd_op == OP_SEOI);
  assign is_seoi_rot = cmd_valid && (cmd_op == OP_SEOI_ROT);
  assign is_setprio  = cmd_valid && (cmd_op == OP_SETPRIO);
  assign is_mask     = cmd_valid && (cmd_op == OP_MASK);
  assign is_trig     = cmd_valid && (cmd_op == OP_TRIG);
  assign is_mode     = cmd_valid && (cmd_op == OP_MODE);

  assign ack_fire = is_ack && int_pending;
  assign ack_clr  = ack_fire ? line_bit(win_line) : '0;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    arb_line_capture u_cap (
      .clk       (clk),
      .rst       (rst),
      .irq_i     (irq_i[i]),
      .level_i   (trig_q[i]),
      .ack_clr_i (ack_clr[i]),
      .irr_o     (irr_q[i])
    );
  end

  always_comb begin
    isr_set = (ack_fire && !aeoi_q) ? line_bit(win_line) : '0;
    isr_clr = '0;
    if ((is_eoi || is_eoi_rot) && svc_any) isr_clr = line_bit(svc_line);
    if (is_seoi || is_seoi_rot)            isr_clr = line_bit(cmd_line);
  end

  always_comb begin
    base_load = 1'b0;
    base_next = base_q;
    if (ack_fire && aeoi_q && raeoi_q) begin
      base_load = 1'b1;
      base_next = after_line(win_line);
    end else if (is_eoi_rot && svc_any) begin
      base_load = 1'b1;
      base_next = after_line(svc_line);
    end else if (is_seoi_rot || is_setprio) begin
      base_load = 1'b1;
      base_next = after_line(cmd_line);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q   <= '0;
      isr_q   <= '0;
      trig_q  <= '0;
      base_q  <= '0;
      aeoi_q  <= 1'b0;
      raeoi_q <= 1'b0;
    end else begin
      isr_q <= (isr_q | isr_set) & ~isr_clr;
      if (base_load) base_q <= base_next;
      if (is_mask)   imr_q  <= cmd_data;
      if (is_trig)   trig_q <= cmd_data;
      if (is_mode) begin
        aeoi_q  <= cmd_data[0];
        raeoi_q <= cmd_data[1];
      end
    end
  end

  // R7
  ack_marks_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !aeoi_q) |=> isr_q[$past(win_line)]);

  // R8
  aeoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && aeoi_q) |=> (isr_q == $past(isr_q)));

  // R3
  free_request_raises_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_vec != '0) && (isr_q == '0)) |-> int_pending);

  // R6
  masked_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    int_pending |-> !imr_q[int_line]);

  // R10
  seoi_clears_chk: assert property (@(posedge clk) disable iff (rst)
    is_seoi |=> !isr_q[$past(cmd_line)]);

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !base_load |=> $stable(base_q));

endmodule

// File: tb/rot_prio_arbiter_tb_top.sv
module rot_prio_arbiter_tb_top;
  import arb_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_i = '0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [2:0] cmd_line = '0;
  logic [7:0] cmd_data = '0;
  logic       int_pending;
  logic [2:0] int_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_arbiter dut_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .cmd_data(cmd_data), .int_pending(int_pending), .int_line(int_line)
  );

  bit [7:0] m_irr, m_last, m_imr, m_isr, m_trig;
  int       m_base;
  bit       m_aeoi, m_raeoi;
  int       n_chk = 0;
  int       n_fail = 0;

  function automatic int rank_of(bit [7:0] v, int b);
    for (int k = 0; k < 8; k++) if (v[(b + k) % 8]) return k;
    return 8;
  endfunction

  task automatic model_step(bit r, int op, int ln, bit [7:0] d, bit [7:0] q);
    int rq, rs, w, sl;
    bit pend;
    if (r) begin
      m_irr = 0; m_last = 0; m_imr = 0; m_isr = 0; m_trig = 0;
      m_base = 0; m_aeoi = 0; m_raeoi = 0;
      return;
    end
    rq = rank_of(m_irr & ~m_imr, m_base);
    rs = rank_of(m_isr, m_base);
    pend = rq < rs;
    w  = (rq + m_base) % 8;
    sl = (rs + m_base) % 8;
    for (int i = 0; i < 8; i++) begin
      if (m_trig[i]) m_irr[i] = q[i];
      else if (q[i] && !m_last[i]) m_irr[i] = 1'b1;
      m_last[i] = q[i];
    end
    case (op)
      1: if (pend) begin
           if (!m_trig[w]) m_irr[w] = 1'b0;
           if (m_aeoi) begin
             if (m_raeoi) m_base = (w + 1) % 8;
           end else m_isr[w] = 1'b1;
         end
      2, 3: if (rs < 8) begin
           m_isr[sl] = 1'b0;
           if (op == 3) m_base = (sl + 1) % 8;
         end
      4: m_isr[ln] = 1'b0;
      5: begin m_isr[ln] = 1'b0; m_base = (ln + 1) % 8; end
      6: m_base = (ln + 1) % 8;
      7: m_imr = d;
      8: m_trig = d;
      9: begin m_aeoi = d[0]; m_raeoi = d[1]; end
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    int rq, el;
    bit ep;
    rq = rank_of(m_irr & ~m_imr, m_base);
    ep = rq < rank_of(m_isr, m_base);
    el = (rq + m_base) % 8;
    n_chk++;
    if (int_pending !== ep || (ep && int_line !== el[2:0])) begin
      n_fail++;
      $display("FAIL %s: pending=%0b line=%0d expected pending=%0b line=%0d",
               tag, int_pending, int_line, ep, el);
    end
  endtask

  task automatic cyc(int op, int ln, bit [7:0] d, bit [7:0] q, string tag);
    cmd_valid = (op != 0);
    cmd_op    = op[3:0];
    cmd_line  = ln[2:0];
    cmd_data  = d;
    irq_i     = q;
    model_step(rst, op, ln, d, q);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    #1;
    // R1: reset with inputs active, then quiet
    rst = 1'b1;
    cyc(0, 0, 8'h00, 8'hFF, "R1");
    cyc(0, 0, 8'h00, 8'hFF, "R1");
    rst = 1'b0;
    cyc(0, 0, 8'h00, 8'h00, "R1");

    // R2/R5: every request pattern at every base, level lines
    cyc(int'(OP_TRIG), 0, 8'hFF, 8'h00, "R5");
    for (int b = 0; b < 8; b++) begin
      cyc(int'(OP_SETPRIO), (b + 7) % 8, 8'h00, 8'h00, "R10");
      for (int p = 1; p < 256; p++) cyc(0, 0, 8'h00, p[7:0], "R2");
      cyc(0, 0, 8'h00, 8'h00, "R5");
    end

    // R3: one line in service against every request pattern
    for (int s = 0; s < 8; s++) begin
      cyc(int'(OP_SETPRIO), (s * 3 + 7) % 8, 8'h00, 8'h00, "R10");
      cyc(0, 0, 8'h00, 8'(1 << s), "R3");
      cyc(int'(OP_ACK), 0, 8'h00, 8'(1 << s), "R7");
      for (int p = 0; p < 256; p++) cyc(0, 0, 8'h00, p[7:0], "R3");
      cyc(int'(OP_SEOI), s, 8'h00, 8'h00, "R10");
    end

    // R4: edge capture
    cyc(int'(OP_TRIG), 0, 8'h00, 8'h00, "R4");
    cyc(int'(OP_SETPRIO), 7, 8'h00, 8'h00, "R10");
    cyc(0, 0, 8'h00, 8'h08, "R4");
    cyc(0, 0, 8'h00, 8'h00, "R4");
    cyc(0, 0, 8'h00, 8'h08, "R4");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h08, "R7");
    cyc(0, 0, 8'h00, 8'h08, "R4");
    cyc(int'(OP_EOI), 0, 8'h00, 8'h08, "R9");
    cyc(0, 0, 8'h00, 8'h00, "R4");
    cyc(0, 0, 8'h00, 8'h08, "R4");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R7");
    cyc(int'(OP_EOI), 0, 8'h00, 8'h00, "R9");

    // R6: mask hides but keeps the request
    cyc(0, 0, 8'h00, 8'h20, "R6");
    cyc(int'(OP_MASK), 0, 8'h20, 8'h00, "R6");
    cyc(0, 0, 8'h00, 8'h00, "R6");
    cyc(int'(OP_MASK), 0, 8'h00, 8'h00, "R6");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R7");
    cyc(int'(OP_EOI), 0, 8'h00, 8'h00, "R9");

    // R7: spurious acknowledge, level line kept after acknowledge
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R7");
    cyc(int'(OP_TRIG), 0, 8'h02, 8'h02, "R7");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h02, "R7");
    cyc(int'(OP_SEOI), 1, 8'h00, 8'h02, "R7");
    cyc(int'(OP_TRIG), 0, 8'h00, 8'h00, "R7");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R7");
    cyc(int'(OP_EOI), 0, 8'h00, 8'h00, "R9");

    // R8: automatic end-of-interrupt, then with rotation
    cyc(int'(OP_MODE), 0, 8'h01, 8'h00, "R8");
    cyc(0, 0, 8'h00, 8'h12, "R8");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h12, "R8");
    cyc(int'(OP_MODE), 0, 8'h03, 8'h00, "R8");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R8");
    cyc(0, 0, 8'h00, 8'h41, "R8");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h41, "R8");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R8");
    cyc(int'(OP_MODE), 0, 8'h00, 8'h00, "R8");

    // R9: non-specific forms
    cyc(int'(OP_SETPRIO), 7, 8'h00, 8'h00, "R10");
    cyc(0, 0, 8'h00, 8'h24, "R9");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R9");
    cyc(0, 0, 8'h00, 8'h02, "R9");
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R9");
    cyc(int'(OP_EOI), 0, 8'h00, 8'h00, "R9");
    cyc(int'(OP_EOI_ROT), 0, 8'h00, 8'h00, "R9");
    cyc(int'(OP_EOI_ROT), 0, 8'h00, 8'h00, "R9");

    // R10: specific rotate
    cyc(int'(OP_ACK), 0, 8'h00, 8'h00, "R10");
    cyc(0, 0, 8'h00, 8'h88, "R10");
    cyc(int'(OP_SEOI_ROT), 5, 8'h00, 8'h88, "R10");
    cyc(0, 0, 8'h00, 8'h00, "R10");

    // R2: mixed random traffic with periodic resets (R1)
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 499) begin
        rst = 1'b1;
        cyc(0, 0, 8'h00, 8'h00, "R1");
        rst = 1'b0;
      end else begin
        cyc($urandom_range(0, 9), $urandom_range(0, 7), 8'($urandom),
            8'($urandom), "R2");
      end
    end

    summary();
    $finish;
  end

endmodule